// File: doc/BRIEF.md
# Guarded Sequence Table Store

This block keeps a table of 64 instruction-sequence words, each 32 bits wide, that a serial flash sequencer fetches when it runs a command. Software reaches the table through a simple word-addressed register port. The sequencer reads any word at any time through a separate combinational port indexed by word number.

The table can be frozen so that stray register writes cannot corrupt it. Freezing and thawing is a two-step operation. Software first writes a fixed 32-bit key to a key register. Its very next register access must then be a write of a command code to the lock control register. A write of 1 freezes the table and a write of 2 thaws it. While the table is frozen, table writes are dropped without any indication. Reads of the table are always allowed. In normal use, software thaws the table, writes zero to every word, programs its sequences, and freezes the table again.

Top module: `seq_table_store`

## Requirements
- R1: After reset the table is unlocked, the lock control register (byte offset 0x304) reads 2, and every table word reads zero on both read ports.
- R2: While unlocked, a register write to byte offset 0x310 + 4*i (i from 0 to 63) stores the data in word i. Writes whose two low address bits are not zero, and writes above the last word (offset 0x410 and up), change no word.
- R3: While locked, a register write to a table word leaves that word unchanged.
- R4: A write of 0x5AF05AF0 to the key register (offset 0x300) followed directly by a write of 1 to offset 0x304 locks the table. The lock control register then reads 1.
- R5: A key write followed by a write of 2 to offset 0x304 unlocks the table. Idle cycles with no register access between the two writes do not cancel the key.
- R6: A lock or unlock write has no effect unless the previous register access was a correct key write. The key is cancelled by any intervening read or write, and a key write with any other value does not arm it.
- R7: A lock control write with a value other than 1 or 2 leaves the lock state unchanged and still uses up the armed key.
- R8: Register reads are allowed in either state. The key register, and any address that maps to nothing, read zero.
- R9: reg_rdata takes the addressed value on the clock edge that samples reg_rd_en, and holds it until the next read.
- R10: seq_word shows, in the same cycle, the stored word selected by seq_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid from the cycle after the read |
| seq_idx | input | 6 | Word index for the sequencer read port |
| seq_word | output | 32 | Table word at seq_idx |

## Verification
The hardest case to reach is the key being silently cancelled. The key must be armed and then spoiled by exactly one unrelated access: a read, a table write, a wrong key value, or a lock command with an unknown code. Only after that does the real lock or unlock command arrive. The stimulus issues accesses back to back with no idle cycles, so each spoiler lands directly between the key and the command. A separate case inserts a deliberate idle gap to show that time alone does not cancel the key. After each attempt, the lock control register and a table word that was written while locked are read back to show whether the state changed.

// File: rtl/seq_table_store.sv
module seq_table_store #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int WORDS = 64,
  parameter logic [AW-1:0] KEY_OFS = 12'h300,
  parameter logic [AW-1:0] LOCK_OFS = 12'h304,
  parameter logic [AW-1:0] TBL_OFS = 12'h310,
  parameter logic [DW-1:0] KEY_VAL = 32'h5AF0_5AF0,
  parameter logic [DW-1:0] CMD_LOCK = 32'd1,
  parameter logic [DW-1:0] CMD_UNLOCK = 32'd2,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic          reg_rd_en,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [IW-1:0] seq_idx,
  output logic [DW-1:0] seq_word
);
  localparam logic [AW:0] TBL_END = {1'b0, TBL_OFS} + (AW+1)'(4 * WORDS);

  logic [DW-1:0] mem [WORDS];
  logic          locked_q;
  logic          armed_q;
  logic [AW-1:0] tbl_off;
  logic [IW-1:0] tbl_idx;
  logic          aligned, tbl_hit, key_hit, lock_hit, key_ok, any_acc;
  logic [DW-1:0] rd_mux;

  assign aligned  = reg_addr[1:0] == 2'b00;
  assign tbl_off  = reg_addr - TBL_OFS;
  assign tbl_idx  = tbl_off[IW+1:2];
  assign tbl_hit  = aligned && reg_addr >= TBL_OFS && {1'b0, reg_addr} < TBL_END;
  assign key_hit  = reg_addr == KEY_OFS;
  assign lock_hit = reg_addr == LOCK_OFS;
  assign key_ok   = reg_wr_en && key_hit && reg_wdata == KEY_VAL;
  assign any_acc  = reg_wr_en || reg_rd_en;
  assign seq_word = mem[seq_idx];

  always_comb begin
    rd_mux = '0;
    if (lock_hit)     rd_mux = locked_q ? CMD_LOCK : CMD_UNLOCK;
    else if (tbl_hit) rd_mux = mem[tbl_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      if (key_ok)       armed_q <= 1'b1;
      else if (any_acc) armed_q <= 1'b0;
      if (reg_wr_en && lock_hit && armed_q) begin
        if (reg_wdata == CMD_LOCK)        locked_q <= 1'b1;
        else if (reg_wdata == CMD_UNLOCK) locked_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (reg_wr_en && tbl_hit && !locked_q) begin
      mem[tbl_idx] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/seq_table_store_chk.sv
module seq_table_store_chk #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int WORDS = 64,
  parameter logic [AW-1:0] KEY_OFS = 12'h300,
  parameter logic [AW-1:0] LOCK_OFS = 12'h304,
  parameter logic [DW-1:0] KEY_VAL = 32'h5AF0_5AF0,
  parameter logic [DW-1:0] CMD_LOCK = 32'd1,
  parameter logic [DW-1:0] CMD_UNLOCK = 32'd2,
  localparam int IW = $clog2(WORDS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr_en,
  input logic          reg_rd_en,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          locked_q,
  input logic          armed_q,
  input logic          tbl_hit,
  input logic [IW-1:0] tbl_idx,
  input logic [DW-1:0] mem [WORDS]
);
  assert_reset_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !locked_q && !armed_q);

  assert_lock_needs_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(armed_q && reg_wr_en && reg_addr == LOCK_OFS && reg_wdata == CMD_LOCK));

  assert_unlock_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_q) |-> $past(armed_q && reg_wr_en && reg_addr == LOCK_OFS && reg_wdata == CMD_UNLOCK));

  assert_key_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en || reg_wr_en) && !(reg_wr_en && reg_addr == KEY_OFS && reg_wdata == KEY_VAL) |=> !armed_q);

  assert_locked_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q && reg_wr_en && tbl_hit |=> mem[$past(tbl_idx)] == $past(mem[tbl_idx]));

  assert_lock_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en && reg_addr == LOCK_OFS |=> reg_rdata == ($past(locked_q) ? CMD_LOCK : CMD_UNLOCK));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rdata));
endmodule

bind seq_table_store seq_table_store_chk #(
  .AW(AW), .DW(DW), .WORDS(WORDS), .KEY_OFS(KEY_OFS), .LOCK_OFS(LOCK_OFS),
  .KEY_VAL(KEY_VAL), .CMD_LOCK(CMD_LOCK), .CMD_UNLOCK(CMD_UNLOCK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .locked_q(locked_q), .armed_q(armed_q), .tbl_hit(tbl_hit), .tbl_idx(tbl_idx),
  .mem(mem)
);

// File: tb/seq_table_store_tb_top.sv
`timescale 1ns/1ps
module seq_table_store_tb_top;
  localparam logic [11:0] A_KEY = 12'h300, A_LOCK = 12'h304, A_TBL = 12'h310;
  localparam logic [31:0] KEY = 32'h5AF0_5AF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  seq_idx = '0;
  logic [31:0] seq_word;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] m_tbl [64];
  bit m_locked = 1'b0, m_armed = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_d = 1'b0;

  always #2 clk = ~clk;

  seq_table_store dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .seq_idx(seq_idx), .seq_word(seq_word)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_tbl(logic [11:0] a);
    return a[1:0] == 2'b00 && a >= A_TBL && a < 12'h410;
  endfunction

  function automatic logic [31:0] pat(int i);
    return {8'hC3, 8'(i), ~8'(i), 8'h5A};
  endfunction

  task automatic do_wr(logic [11:0] a, logic [31:0] d);
    if (a == A_KEY) m_armed = (d == KEY);
    else begin
      if (a == A_LOCK && m_armed) begin
        if (d == 32'd1) m_locked = 1'b1;
        else if (d == 32'd2) m_locked = 1'b0;
      end else if (is_tbl(a) && !m_locked) m_tbl[(a - A_TBL) >> 2] = d;
      m_armed = 1'b0;
    end
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic do_rd(logic [11:0] a, string tag);
    logic [31:0] e;
    e = '0;
    if (a == A_LOCK) e = m_locked ? 32'd1 : 32'd2;
    else if (is_tbl(a)) e = m_tbl[(a - A_TBL) >> 2];
    exp_q.push_back(e);
    tag_q.push_back(tag);
    m_armed = 1'b0;
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exec_chk(int i, string tag);
    seq_idx = 6'(i);
    #1;
    check(tag, seq_word, m_tbl[i]);
  endtask

  always @(posedge clk) rd_d <= reg_rd_en;

  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) check("queue underflow", 32'd1, 32'd0);
      else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    do_rd(A_LOCK, "R1 lock reads 2 after reset");
    do_rd(A_TBL, "R1 word 0 zero");
    do_rd(A_TBL + 12'd252, "R1 word 63 zero");
    exec_chk(5, "R1 exec port zero");

    for (int i = 0; i < 64; i++) do_wr(A_TBL + 12'(4 * i), pat(i));
    do_rd(A_TBL, "R2 word 0");
    do_rd(A_TBL + 12'd4 * 12'd17, "R2 word 17");
    do_rd(A_TBL + 12'd252, "R2 word 63");
    exec_chk(0, "R10 exec word 0");
    exec_chk(42, "R10 exec word 42");
    exec_chk(63, "R10 exec word 63");
    do_wr(A_TBL + 12'd9, 32'hDEAD0001);
    do_wr(12'h410, 32'hDEAD0002);
    do_rd(A_TBL + 12'd8, "R2 unaligned write ignored");
    exec_chk(2, "R2 unaligned write ignored exec");
    do_rd(A_TBL + 12'd252, "R2 write above table ignored");

    do_wr(A_LOCK, 32'd1);
    do_rd(A_LOCK, "R6 lock without key");
    do_wr(A_KEY, KEY); do_rd(A_TBL, "R6 read between"); do_wr(A_LOCK, 32'd1);
    do_rd(A_LOCK, "R6 read cancels key");
    do_wr(A_KEY, KEY); do_wr(A_TBL + 12'd4, 32'h0000_1111); do_wr(A_LOCK, 32'd1);
    do_rd(A_LOCK, "R6 table write cancels key");
    do_wr(A_KEY, KEY ^ 32'h1); do_wr(A_LOCK, 32'd1);
    do_rd(A_LOCK, "R6 wrong key");

    do_wr(A_KEY, KEY); do_wr(A_LOCK, 32'd1);
    do_rd(A_LOCK, "R4 lock reads 1");
    do_wr(A_TBL + 12'd12, 32'hBAD0BAD0);
    do_rd(A_TBL + 12'd12, "R3 locked write ignored");
    exec_chk(3, "R3 locked write ignored exec");
    do_rd(A_TBL + 12'd4, "R8 read while locked");

    do_wr(A_KEY, KEY); do_wr(A_LOCK, 32'd7);
    do_rd(A_LOCK, "R7 unknown code no change");
    do_wr(A_KEY, KEY); do_wr(A_LOCK, 32'd7); do_wr(A_LOCK, 32'd2);
    do_rd(A_LOCK, "R7 unknown code uses key");

    do_wr(A_KEY, KEY); idle(3); do_wr(A_LOCK, 32'd2);
    do_rd(A_LOCK, "R5 unlock after idle gap");
    do_wr(A_TBL + 12'd12, 32'h600D600D);
    do_rd(A_TBL + 12'd12, "R5 write after unlock");

    do_rd(A_KEY, "R8 key reads zero");
    do_rd(12'h200, "R8 unmapped reads zero");
    idle(2);
    check("R9 rdata holds", reg_rdata, 32'd0);

    for (int i = 0; i < 64; i++) do_wr(A_TBL + 12'(4 * i), 32'd0);
    do_rd(A_TBL + 12'd128, "R2 cleared word 32");
    exec_chk(63, "R10 cleared word 63");

    idle(3);
    check("queue drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule